// File: doc/BRIEF.md
# Teletext Bit Request Controller

This block pulls a serial teletext bit stream from an outside source during a fixed-length insertion window on chosen vertical-blanking lines. It runs entirely on the pixel clock. At each horizontal start pulse it checks the current line number and field against two per-field line masks. On an enabled line it waits a programmed number of pixel clocks and then opens a window whose length in bits depends on the selected teletext standard. The clock run-in bits are part of that count.

Bit timing inside the window comes from a fractional phase accumulator. The accumulator adds a programmed increment on every clock, and each carry out of it marks one bit boundary. Two handshakes with the source are offered. In the first, the request output pulses once per bit, and the source presents that bit on the serial input a programmed number of clocks later. In the second, the request output rises once when the window opens and stays high until the window closes. The block samples the serial input at each bit boundary plus the programmed delay, and it presents the sampled bit with a one-cycle valid flag.

Top module: `ttx_req_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no enabled line seen, `txt_req` and `bit_valid` are 0.
- R2: The window holds 360 bits for `cfg_std`=0, 296 bits for `cfg_std`=1, and 288 bits for `cfg_std`=2 or 3.
- R3: With `cfg_proto`=0, `txt_req` is high for exactly one clock per bit, so a full window gives as many rising edges as it has bits. The bit period is P = 2^16 / `cfg_phase_inc` clocks and must be at least 2. The first request rises P clocks after the window opens.
- R4: With `cfg_proto`=1, `txt_req` rises once per line, when the window opens. It stays high for P times the window bit count, unless R8 cuts it short.
- R5: When `hstart` is sampled high at clock edge H on an enabled line, the window opens at edge H+1+`cfg_wstart`. With `cfg_proto`=1, `txt_req` goes high at that edge.
- R6: Each bit boundary in the window produces a strobe at the clock edge that follows it. With `cfg_proto`=0 this strobe is the request pulse. At `cfg_dly` (0 to 15) clocks after the strobe edge plus one, `txt_in` is sampled into `bit_data`, and `bit_valid` goes high for one clock.
- R7: A line is enabled only when `line_num` lies from 6 to 21. The selecting mask bit is bit (`line_num` − 6) of `mask_f0` when `field_id`=0, or of `mask_f1` when `field_id`=1. On any other line `txt_req` stays low.
- R8: A new `hstart` ends any open window. `txt_req` is low after that edge, and no bit strobe is produced at it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst_n | input | 1 | asynchronous active-low reset |
| line_num | input | 10 | current line number |
| field_id | input | 1 | 0 for first field, 1 for second |
| hstart | input | 1 | one-clock pulse at the start of each line |
| txt_in | input | 1 | serial teletext data from the source |
| cfg_std | input | 2 | standard select, sets window bit count |
| cfg_proto | input | 1 | 0 per-bit pulse, 1 held window |
| cfg_dly | input | 4 | capture delay after each bit strobe |
| cfg_wstart | input | 12 | clocks from line start to window open |
| cfg_phase_inc | input | 16 | phase increment per clock |
| mask_f0 | input | 16 | line enables for the first field |
| mask_f1 | input | 16 | line enables for the second field |
| txt_req | output | 1 | request to the teletext source |
| bit_data | output | 1 | last captured bit |
| bit_valid | output | 1 | one-clock flag for a new captured bit |

## Verification
A wrong bit counter or a wrong standard decode shows in the request count or the held-high length. It becomes visible when the window closes on the first enabled line. A wrong window start or a wrong phase accumulator shifts the first request edge, so the error is seen within one bit period of the window opening. A wrong capture tap, or a delay line off by one, makes the first captured bit disagree with the data, because the source holds the inverted value on every clock except the intended sampling slot. A wrong mask or field selection raises a request on a line that should stay silent, and this shows within one window start plus one bit period.

// File: rtl/ttx_req_pkg.sv
package ttx_req_pkg;

  localparam int unsigned BITCNT_W = 9;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SEND = 2'd2
  } win_state_t;

  typedef enum logic [1:0] {
    STD_625  = 2'd0,
    STD_525  = 2'd1,
    STD_NA   = 2'd2,
    STD_RSVD = 2'd3
  } txt_std_t;

  // bits per insertion window, run-in included
  function automatic logic [BITCNT_W-1:0] window_bits(input logic [1:0] std_sel);
    logic [BITCNT_W-1:0] n;
    case (txt_std_t'(std_sel))
      STD_625: n = BITCNT_W'(360);
      STD_525: n = BITCNT_W'(296);
      default: n = BITCNT_W'(288);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/ttx_line_gate.sv
module ttx_line_gate #(
  parameter int unsigned LINE_W     = 10,
  parameter int unsigned FIRST_LINE = 6,
  parameter int unsigned NUM_LINES  = 16
) (
  input  logic [LINE_W-1:0]    line_num,
  input  logic                 field_id,
  input  logic [NUM_LINES-1:0] mask_f0,
  input  logic [NUM_LINES-1:0] mask_f1,
  output logic                 line_ok
);

  logic [NUM_LINES-1:0] hit;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam logic [LINE_W-1:0] LINE_NO = LINE_W'(FIRST_LINE + i);
    assign hit[i] = (line_num == LINE_NO) && (field_id ? mask_f1[i] : mask_f0[i]);
  end

  assign line_ok = |hit;

endmodule

// File: rtl/ttx_phase_acc.sv
module ttx_phase_acc #(
  parameter int unsigned ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [ACC_W-1:0] inc,
  output logic             bit_tick
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum      = {1'b0, acc_q} + {1'b0, inc};
    bit_tick = run & sum[ACC_W];
    if (clr)      acc_d = '0;
    else if (run) acc_d = sum[ACC_W-1:0];
    else          acc_d = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

endmodule

// File: rtl/ttx_window_fsm.sv
module ttx_window_fsm
  import ttx_req_pkg::*;
#(
  parameter int unsigned POS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hstart,
  input  logic             line_ok,
  input  logic [POS_W-1:0] wstart,
  input  logic [1:0]       std_sel,
  input  logic             proto,
  input  logic             bit_tick,
  output logic             acc_clr,
  output logic             acc_run,
  output logic             pulse,
  output logic             req
);

  win_state_t           state_q, state_d;
  logic [POS_W-1:0]     pos_q, pos_d;
  logic [BITCNT_W-1:0]  cnt_q, cnt_d;
  logic [BITCNT_W-1:0]  win_len;
  logic                 last_bit;
  logic                 pulse_q, pulse_d;
  logic                 req_q, req_d;

  always_comb begin
    state_d  = state_q;
    pos_d    = pos_q;
    cnt_d    = cnt_q;
    acc_clr  = 1'b0;
    win_len  = window_bits(std_sel);
    last_bit = (cnt_q == win_len - 1'b1);
    if (hstart) begin
      state_d = line_ok ? ST_WAIT : ST_IDLE;
      pos_d   = '0;
      cnt_d   = '0;
    end else begin
      case (state_q)
        ST_WAIT: begin
          if (pos_q == wstart) begin
            state_d = ST_SEND;
            cnt_d   = '0;
            acc_clr = 1'b1;
          end else begin
            pos_d = pos_q + 1'b1;
          end
        end
        ST_SEND: begin
          if (bit_tick) begin
            if (last_bit) state_d = ST_IDLE;
            else          cnt_d   = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
    pulse_d = bit_tick && (state_q == ST_SEND) && !hstart;
    req_d   = proto ? (state_d == ST_SEND) : pulse_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
      req_q   <= req_d;
    end
  end

  assign acc_run = (state_q == ST_SEND);
  assign pulse   = pulse_q;
  assign req     = req_q;

endmodule

// File: rtl/ttx_capture.sv
module ttx_capture #(
  parameter int unsigned DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse,
  input  logic [DLY_W-1:0] dly,
  input  logic             txt_in,
  output logic             bit_data,
  output logic             bit_valid
);

  localparam int unsigned DEPTH = 1 << DLY_W;

  logic [DEPTH-2:0] hist_q;
  logic [DEPTH-1:0] taps;
  logic             sample;
  logic             data_q, data_d;
  logic             vld_q;

  always_comb begin
    taps   = {hist_q, pulse};
    sample = taps[dly];
    data_d = sample ? txt_in : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      data_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      hist_q <= taps[DEPTH-2:0];
      data_q <= data_d;
      vld_q  <= sample;
    end
  end

  assign bit_data  = data_q;
  assign bit_valid = vld_q;

endmodule

// File: rtl/ttx_req_ctrl.sv
module ttx_req_ctrl #(
  parameter int unsigned LINE_W     = 10,
  parameter int unsigned FIRST_LINE = 6,
  parameter int unsigned NUM_LINES  = 16,
  parameter int unsigned POS_W      = 12,
  parameter int unsigned ACC_W      = 16,
  parameter int unsigned DLY_W      = 4,
  parameter int unsigned SYNC_STG   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LINE_W-1:0]    line_num,
  input  logic                 field_id,
  input  logic                 hstart,
  input  logic                 txt_in,
  input  logic [1:0]           cfg_std,
  input  logic                 cfg_proto,
  input  logic [DLY_W-1:0]     cfg_dly,
  input  logic [POS_W-1:0]     cfg_wstart,
  input  logic [ACC_W-1:0]     cfg_phase_inc,
  input  logic [NUM_LINES-1:0] mask_f0,
  input  logic [NUM_LINES-1:0] mask_f1,
  output logic                 txt_req,
  output logic                 bit_data,
  output logic                 bit_valid
);

  logic [SYNC_STG-1:0] rst_sync_q;
  logic                rst_int_n;
  logic                line_ok;
  logic                acc_clr;
  logic                acc_run;
  logic                bit_tick;
  logic                pulse;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STG-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STG-1];

  ttx_line_gate #(
    .LINE_W    (LINE_W),
    .FIRST_LINE(FIRST_LINE),
    .NUM_LINES (NUM_LINES)
  ) u_gate (
    .line_num(line_num),
    .field_id(field_id),
    .mask_f0 (mask_f0),
    .mask_f1 (mask_f1),
    .line_ok (line_ok)
  );

  ttx_phase_acc #(
    .ACC_W(ACC_W)
  ) u_phase (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (acc_clr),
    .run     (acc_run),
    .inc     (cfg_phase_inc),
    .bit_tick(bit_tick)
  );

  ttx_window_fsm #(
    .POS_W(POS_W)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .hstart  (hstart),
    .line_ok (line_ok),
    .wstart  (cfg_wstart),
    .std_sel (cfg_std),
    .proto   (cfg_proto),
    .bit_tick(bit_tick),
    .acc_clr (acc_clr),
    .acc_run (acc_run),
    .pulse   (pulse),
    .req     (txt_req)
  );

  ttx_capture #(
    .DLY_W(DLY_W)
  ) u_cap (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pulse    (pulse),
    .dly      (cfg_dly),
    .txt_in   (txt_in),
    .bit_data (bit_data),
    .bit_valid(bit_valid)
  );

endmodule

// File: rtl/ttx_req_ctrl_chk.sv
module ttx_req_ctrl_chk #(
  parameter int unsigned LINE_W     = 10,
  parameter int unsigned FIRST_LINE = 6,
  parameter int unsigned NUM_LINES  = 16,
  parameter int unsigned POS_W      = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 hstart,
  input logic                 field_id,
  input logic [LINE_W-1:0]    line_num,
  input logic [NUM_LINES-1:0] mask_f0,
  input logic [NUM_LINES-1:0] mask_f1,
  input logic                 cfg_proto,
  input logic [POS_W-1:0]     cfg_wstart,
  input logic                 txt_req,
  input logic                 bit_valid
);

  logic           sel_line;
  logic           quiet_q;
  logic           rise_seen_q;
  logic           req_d_q;
  logic [POS_W:0] since_q;

  always_comb begin
    sel_line = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (line_num == LINE_W'(FIRST_LINE + i))
        sel_line = field_id ? mask_f1[i] : mask_f0[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_q     <= 1'b1;
      rise_seen_q <= 1'b0;
      req_d_q     <= 1'b0;
      since_q     <= '0;
    end else begin
      req_d_q <= txt_req;
      if (hstart) begin
        quiet_q     <= !sel_line;
        rise_seen_q <= 1'b0;
        since_q     <= '0;
      end else begin
        if (txt_req && !req_d_q) rise_seen_q <= 1'b1;
        if (since_q != '1)       since_q     <= since_q + 1'b1;
      end
    end
  end

  // R3
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_proto && txt_req) |=> !txt_req);

  // R4
  held_rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_proto && $rose(txt_req)) |-> !rise_seen_q);

  // R5
  window_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_proto && $rose(txt_req)) |-> (since_q == ({1'b0, cfg_wstart} + 1'b1)));

  // R6
  valid_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);

  // R7
  quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_q |-> !txt_req);

  // R8
  line_end_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hstart |=> !txt_req);

endmodule

bind ttx_req_ctrl ttx_req_ctrl_chk #(
  .LINE_W    (LINE_W),
  .FIRST_LINE(FIRST_LINE),
  .NUM_LINES (NUM_LINES),
  .POS_W     (POS_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hstart    (hstart),
  .field_id  (field_id),
  .line_num  (line_num),
  .mask_f0   (mask_f0),
  .mask_f1   (mask_f1),
  .cfg_proto (cfg_proto),
  .cfg_wstart(cfg_wstart),
  .txt_req   (txt_req),
  .bit_valid (bit_valid)
);

// File: tb/tb_ttx_req_ctrl.sv
module tb_ttx_req_ctrl;

  localparam int CLK_NS = 20;

  logic        clk;
  logic        rst_n;
  logic [9:0]  line_num;
  logic        field_id;
  logic        hstart;
  logic        txt_in;
  logic [1:0]  cfg_std;
  logic        cfg_proto;
  logic [3:0]  cfg_dly;
  logic [11:0] cfg_wstart;
  logic [15:0] cfg_phase_inc;
  logic [15:0] mask_f0;
  logic [15:0] mask_f1;
  logic        txt_req;
  logic        bit_data;
  logic        bit_valid;

  ttx_req_ctrl dut (
    .clk(clk), .rst_n(rst_n), .line_num(line_num), .field_id(field_id),
    .hstart(hstart), .txt_in(txt_in), .cfg_std(cfg_std), .cfg_proto(cfg_proto),
    .cfg_dly(cfg_dly), .cfg_wstart(cfg_wstart), .cfg_phase_inc(cfg_phase_inc),
    .mask_f0(mask_f0), .mask_f1(mask_f1), .txt_req(txt_req),
    .bit_data(bit_data), .bit_valid(bit_valid)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  int nchk = 0;
  int nbad = 0;
  bit done = 0;
  bit exp_q[$];

  // per-line bookkeeping of the bench model
  int cur_ws, cur_dly, cur_L, cur_len, cur_P, cur_seed;
  int c_now, rises, highs;
  bit req_prev;
  bit a_on;  int a_j, a_idx, a_dly, a_seed;
  bit b_on;  int b_j, b_sn, b_nb, b_P, b_dly, b_seed;
  bit have_prev;
  int exp_r, exp_h;
  string tag_r, tag_h;

  task automatic chk(input bit ok, input string rq, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
    end
  endtask

  function automatic bit pat(input int n, input int seed);
    return 1'((n * 5) ^ (n >> 2) ^ seed);
  endfunction

  function automatic int nbits_fit(input int L, input int ws, input int P, input int len);
    int n;
    n = (L - 2 - ws) / P;
    if (n > len) n = len;
    return n;
  endfunction

  // one clock of driving and observing, at the falling edge
  task automatic tick_cycle(input bit hs);
    bit b;
    bit rose;
    @(negedge clk);
    hstart = hs;
    rose = txt_req && !req_prev;
    if (txt_req) highs++;
    if (rose) begin
      rises++;
      if (cfg_proto) begin
        // R5: window opens at edge H+1+ws, seen at this falling edge
        chk(c_now == cur_ws + 2, "R5", c_now, cur_ws + 2);
        b_on = 1; b_j = 0; b_sn = 0; b_P = cur_P; b_dly = cur_dly; b_seed = cur_seed;
        b_nb = nbits_fit(cur_L, cur_ws, cur_P, cur_len);
      end else begin
        // R3: first pulse P clocks after window opens
        if (rises == 1) chk(c_now == cur_ws + 2 + cur_P, "R3", c_now, cur_ws + 2 + cur_P);
        a_on = 1; a_j = 0; a_dly = cur_dly; a_seed = cur_seed;
      end
    end
    req_prev = txt_req;
    txt_in = 1'b0;
    if (a_on) begin
      b = pat(a_idx, a_seed);
      if (a_j == a_dly) begin
        txt_in = b; exp_q.push_back(b); a_idx++; a_on = 0;
      end else begin
        txt_in = ~b;
      end
      a_j++;
    end
    if (b_on) begin
      if (b_sn >= b_nb) begin
        b_on = 0;
      end else begin
        b = pat(b_sn, b_seed);
        if (b_j == b_P * (b_sn + 1) + b_dly) begin
          txt_in = b; exp_q.push_back(b); b_sn++;
        end else begin
          txt_in = ~b;
        end
        b_j++;
      end
    end
    c_now++;
  endtask

  task automatic run_line(input int line, input bit fld, input int L, input bit proto,
                          input int std, input int ws, input int dly, input int P,
                          input bit en);
    int len;
    len = (std == 0) ? 360 : (std == 1) ? 296 : 288;
    line_num = 10'(line); field_id = fld;
    cfg_proto = proto; cfg_std = 2'(std); cfg_wstart = 12'(ws); cfg_dly = 4'(dly);
    cfg_phase_inc = 16'(65536 / P);
    c_now = 0;
    tick_cycle(1'b1);
    if (have_prev) begin
      chk(rises == exp_r, tag_r, rises, exp_r);
      chk(highs == exp_h, tag_h, highs, exp_h);
    end
    rises = 0; highs = 0;
    if (txt_req) highs = 0;
    cur_ws = ws; cur_dly = dly; cur_L = L; cur_len = len; cur_P = P;
    if (en) begin cur_seed = line; a_idx = 0; end
    for (int c = 1; c < L; c++) tick_cycle(1'b0);
    have_prev = 1;
    if (!en) begin
      exp_r = 0; exp_h = 0; tag_r = "R7"; tag_h = "R7";
    end else begin
      int nb;
      nb = nbits_fit(L, ws, P, len);
      if (!proto) begin
        exp_r = nb; exp_h = nb;
        tag_r = (nb < len) ? "R8" : "R3";
        tag_h = (nb < len) ? "R8" : "R2";
      end else begin
        exp_r = 1;
        exp_h = (P * len < L - 1 - ws) ? P * len : L - 1 - ws;
        tag_r = "R4";
        tag_h = (P * len > L - 1 - ws) ? "R8" : "R2";
      end
    end
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (rst_n && bit_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6", 1, 0);
      end else begin
        bit e;
        e = exp_q.pop_front();
        chk(bit_data == e, "R6", int'(bit_data), int'(e));
      end
    end
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hstart = 1'b0; txt_in = 1'b0; line_num = '0; field_id = 1'b0;
    cfg_std = '0; cfg_proto = 1'b0; cfg_dly = '0; cfg_wstart = '0;
    cfg_phase_inc = 16'd8192; mask_f0 = 16'h0011; mask_f1 = 16'h4000;
    req_prev = 0; a_on = 0; b_on = 0; have_prev = 0; rises = 0; highs = 0;
    repeat (3) @(negedge clk);
    chk(txt_req == 1'b0, "R1", int'(txt_req), 0);
    chk(bit_valid == 1'b0, "R1", int'(bit_valid), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(txt_req == 1'b0, "R1", int'(txt_req), 0);
    chk(bit_valid == 1'b0, "R1", int'(bit_valid), 0);

    // full windows, per-bit pulse handshake
    run_line(10, 0, 10 + 8 * 360 + 40, 0, 0, 10, 0, 8, 1);
    run_line(20, 1, 3 + 8 * 296 + 40, 0, 1, 3, 3, 8, 1);
    run_line(6, 0, 0 + 8 * 288 + 40, 0, 2, 0, 6, 8, 1);
    // full windows, held handshake
    run_line(10, 0, 40 + 8 * 360 + 40, 1, 0, 40, 2, 8, 1);
    run_line(20, 1, 0 + 8 * 296 + 40, 1, 1, 0, 0, 8, 1);
    run_line(6, 0, 7 + 8 * 288 + 40, 1, 2, 7, 5, 8, 1);
    // shorter bit period, reserved standard code
    run_line(6, 0, 5 + 4 * 288 + 40, 0, 3, 5, 2, 4, 1);
    // masked lines and wrong field
    run_line(11, 0, 200, 0, 0, 5, 1, 8, 0);
    run_line(10, 1, 200, 1, 0, 5, 1, 8, 0);
    mask_f0 = 16'hFFFF; mask_f1 = 16'hFFFF;
    // outside the selectable range
    run_line(5, 0, 200, 1, 0, 5, 1, 8, 0);
    run_line(22, 1, 200, 0, 0, 5, 1, 8, 0);
    // line end cuts the window short, last selectable line
    run_line(21, 0, 500, 0, 0, 10, 2, 8, 1);
    run_line(30, 0, 30, 0, 0, 10, 2, 8, 0);
    run_line(21, 1, 400, 1, 0, 10, 2, 8, 1);
    run_line(30, 0, 30, 1, 0, 10, 2, 8, 0);

    // R6: every expected bit was captured
    chk(exp_q.size() == 0, "R6", exp_q.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule